// File: doc/BRIEF.md
# Peripheral Task Event Register Unit

This block is the software-facing register front end of a single peripheral. Software starts peripheral actions by writing a one to a task address. The block turns that write into a single-cycle trigger pulse on a task output. The peripheral reports activity through single-cycle event input pulses. Each pulse is held in a readable event flag until software clears it.

An interrupt enable mask selects which held flags drive the interrupt line. The mask has three write addresses: one replaces the whole mask, one sets bits where a one is written, and one clears bits where a one is written. The line is a level: it stays high while any enabled flag is set.

A shortcut register links event k to task k for the first N_SHORT events. With a link enabled, the peripheral starts its next action on an event without waiting for software.

Top module: `task_event_regs`

The address map uses word addresses, and all registers sit in bits starting at bit 0:

| Register | Address |
|---|---|
| Tasks | 0x00 + i |
| Event flags | 0x40 + i |
| Shortcut register | 0x80 |
| Whole-mask enable | 0x84 |
| Enable-set | 0x85 |
| Enable-clear | 0x86 |

## Requirements
- R1: A write with wdata[0]=1 to task address 0x00+i drives task_o[i] high for exactly the one cycle after the write edge. No other task bit is raised by that write.
- R2: A write with wdata[0]=0 to a task address raises no task output. A read of any task address returns 0.
- R3: An evt_in[i] pulse sampled at an edge sets event flag i. Address 0x40+i then reads the flag in bit 0, with all other bits 0.
- R4: A write with wdata[0]=0 to address 0x40+i clears flag i. A write with wdata[0]=1 leaves the flag unchanged.
- R5: When evt_in[i] and a clearing write to flag i occur at the same edge, the flag ends set.
- R6: A write to 0x85 sets the enable bits where wdata is 1. A write to 0x86 clears the enable bits where wdata is 1. Zero bits leave the enables unchanged.
- R7: A write to 0x84 loads the whole enable mask. Reads of 0x84, 0x85 and 0x86 all return the mask in bits N_EVT-1:0.
- R8: irq is high exactly while some flag i and enable bit i are both 1, as a level.
- R9: The shortcut register at 0x80 is readable and writable in bits N_SHORT-1:0. With bit k set, an evt_in[k] pulse at edge t raises task_o[k] for one cycle after edge t+1. With bit k clear, the pulse triggers nothing.
- R10: After reset, all flags, enables, shortcuts, task outputs and irq are 0.
- R11: Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| evt_in | input | N_EVT | Event pulses from the peripheral |
| task_o | output | N_TASK | Task trigger pulses to the peripheral |
| irq | output | 1 | Level interrupt |

## Verification
The assertions are checked on every cycle. They cover the following:
- a task write of one leads to a pulse on the next cycle;
- an event pulse sets its flag;
- the set and clear ports change only the written mask bits;
- an enabled shortcut produces its task pulse two edges after the event;
- task reads return zero;
- irq cannot fall unless a write occurs.

The bench's reference model covers what needs a history or a specific ordering. This includes the set-wins rule for a same-cycle clear, write-one having no effect on flags, and unmapped addresses staying inert. It also checks that the shortcut register value is the one sampled before a same-edge write.

// File: rtl/task_event_regs.sv
module task_event_regs #(
  parameter int N_TASK    = 4,
  parameter int N_EVT     = 4,
  parameter int N_SHORT   = 4,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int TASK_BASE = 'h00,
  parameter int EVT_BASE  = 'h40,
  parameter int SHORT_ADR = 'h80,
  parameter int MASK_ADR  = 'h84,
  parameter int SET_ADR   = 'h85,
  parameter int CLR_ADR   = 'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_EVT-1:0]  evt_in,
  output logic [N_TASK-1:0] task_o,
  output logic              irq
);
  localparam logic [AW-1:0] TASK_A  = AW'(TASK_BASE);
  localparam logic [AW-1:0] EVT_A   = AW'(EVT_BASE);
  localparam logic [AW-1:0] SHORT_A = AW'(SHORT_ADR);
  localparam logic [AW-1:0] MASK_A  = AW'(MASK_ADR);
  localparam logic [AW-1:0] SET_A   = AW'(SET_ADR);
  localparam logic [AW-1:0] CLR_A   = AW'(CLR_ADR);

  logic [N_EVT-1:0]   ev_q, inten_q, ev_clr;
  logic [N_SHORT-1:0] short_q, hit_q;
  logic [N_TASK-1:0]  task_q, sw_trig, sc_trig;

  for (genvar i = 0; i < N_TASK; i++) begin : g_task
    assign sw_trig[i] = bus_we && bus_wdata[0] && (bus_addr == TASK_A + AW'(i));
    if (i < N_SHORT) begin : g_sc
      assign sc_trig[i] = hit_q[i];
    end else begin : g_nosc
      assign sc_trig[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    assign ev_clr[i] = bus_we && !bus_wdata[0] && (bus_addr == EVT_A + AW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q    <= '0;
      inten_q <= '0;
      short_q <= '0;
      hit_q   <= '0;
      task_q  <= '0;
    end else begin
      task_q <= sw_trig | sc_trig;
      hit_q  <= evt_in[N_SHORT-1:0] & short_q;
      ev_q   <= (ev_q & ~ev_clr) | evt_in;
      if (bus_we) begin
        if (bus_addr == MASK_A) inten_q <= bus_wdata[N_EVT-1:0];
        if (bus_addr == SET_A)  inten_q <= inten_q | bus_wdata[N_EVT-1:0];
        if (bus_addr == CLR_A)  inten_q <= inten_q & ~bus_wdata[N_EVT-1:0];
        if (bus_addr == SHORT_A) short_q <= bus_wdata[N_SHORT-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_EVT; i++)
      if (bus_addr == EVT_A + AW'(i)) bus_rdata[0] = ev_q[i];
    if (bus_addr == MASK_A || bus_addr == SET_A || bus_addr == CLR_A)
      bus_rdata[N_EVT-1:0] = inten_q;
    if (bus_addr == SHORT_A)
      bus_rdata[N_SHORT-1:0] = short_q;
  end

  assign task_o = task_q;
  assign irq    = |(ev_q & inten_q);
endmodule

// File: rtl/task_event_regs_chk.sv
module task_event_regs_chk #(
  parameter int N_TASK    = 4,
  parameter int N_EVT     = 4,
  parameter int N_SHORT   = 4,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int TASK_BASE = 'h00,
  parameter int SET_ADR   = 'h85,
  parameter int CLR_ADR   = 'h86
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_we,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [N_EVT-1:0]  evt_in,
  input logic [N_TASK-1:0] task_o,
  input logic              irq,
  input logic [N_EVT-1:0]  ev_q,
  input logic [N_EVT-1:0]  inten_q,
  input logic [N_SHORT-1:0] short_q
);
  localparam logic [AW-1:0] TASK_A = AW'(TASK_BASE);
  localparam logic [AW-1:0] SET_A  = AW'(SET_ADR);
  localparam logic [AW-1:0] CLR_A  = AW'(CLR_ADR);

  for (genvar i = 0; i < N_TASK; i++) begin : g_t
    a_r1_task_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata[0] && bus_addr == TASK_A + AW'(i)) |=> task_o[i]);
    a_r2_task_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == TASK_A + AW'(i)) |-> (bus_rdata == '0));
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_e
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_in[i] |=> ev_q[i]);
  end

  for (genvar k = 0; k < N_SHORT; k++) begin : g_s
    a_r9_shortcut_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in[k] && short_q[k]) |=> ##1 task_o[k]);
  end

  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == SET_A) |=>
      ((inten_q & $past(bus_wdata[N_EVT-1:0])) == $past(bus_wdata[N_EVT-1:0])));
  a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CLR_A) |=> ((inten_q & $past(bus_wdata[N_EVT-1:0])) == '0));
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_we) |=> irq);
endmodule

bind task_event_regs task_event_regs_chk #(
  .N_TASK(N_TASK), .N_EVT(N_EVT), .N_SHORT(N_SHORT), .AW(AW), .DW(DW),
  .TASK_BASE(TASK_BASE), .SET_ADR(SET_ADR), .CLR_ADR(CLR_ADR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
  .task_o(task_o), .irq(irq), .ev_q(ev_q), .inten_q(inten_q), .short_q(short_q)
);

// File: tb/task_event_regs_bench.sv
module task_event_regs_bench;
  localparam int NT = 4, NE = 4, NS = 4;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0;
  logic we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NE-1:0] evt = 0;
  logic [NT-1:0] task_o;
  logic irq;
  int errors = 0, checks = 0;

  logic [NE-1:0] m_flag = 0, m_mask = 0;
  logic [NS-1:0] m_short = 0, m_hit = 0;
  logic [NT-1:0] m_task = 0;

  always #10 clk = ~clk;

  task_event_regs u_task_event_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .evt_in(evt), .task_o(task_o), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = 0;
    if (a >= 8'h40 && a < 8'h40 + NE) r[0] = m_flag[a - 8'h40];
    else if (a == 8'h84 || a == 8'h85 || a == 8'h86) r[NE-1:0] = m_mask;
    else if (a == 8'h80) r[NS-1:0] = m_short;
    return r;
  endfunction

  function automatic string area(input logic [7:0] a);
    if (a < NT) return "R2";
    if (a >= 8'h40 && a < 8'h40 + NE) return "R3";
    if (a == 8'h80) return "R9";
    if (a >= 8'h84 && a <= 8'h86) return "R7";
    return "R11";
  endfunction

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [NE-1:0] e);
    logic [NT-1:0] sw = 0;
    logic [NE-1:0] clr = 0;
    we = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    if (w && a < NT && d[0]) sw[a[1:0]] = 1'b1;
    if (w && a >= 8'h40 && a < 8'h40 + NE && !d[0]) clr[a[1:0]] = 1'b1;
    m_task = sw | NT'(m_hit);
    m_hit  = e[NS-1:0] & m_short;
    m_flag = (m_flag & ~clr) | e;
    if (w && a == 8'h84) m_mask = d[NE-1:0];
    if (w && a == 8'h85) m_mask = m_mask | d[NE-1:0];
    if (w && a == 8'h86) m_mask = m_mask & ~d[NE-1:0];
    if (w && a == 8'h80) m_short = d[NS-1:0];
    @(negedge clk);
    chk("R1/R9 task_o", 32'(task_o), 32'(m_task));
    chk("R8 irq", 32'(irq), 32'(|(m_flag & m_mask)));
    chk({area(a), " rdata"}, rdata, exp_read(a));
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 task_o", 32'(task_o), 0);
    chk("R10 irq", 32'(irq), 0);
    for (int a = 0; a < 8'h90; a++) begin addr = 8'(a); #1 chk("R10 rdata", rdata, 0); end
    rst_n = 1;
    @(negedge clk);
    // R1 single task pulse, R2 zero write
    step(1, 8'h02, 1, 0);
    step(0, 8'h02, 0, 0);
    step(1, 8'h01, 0, 0);
    // R3 set, R4 write-one keeps, write-zero clears
    step(0, 8'h43, 0, 4'b1000);
    step(1, 8'h43, 1, 0);
    chk("R4 write one keeps", rdata, 1);
    step(1, 8'h43, 0, 0);
    chk("R4 write zero clears", rdata, 0);
    // R5 set wins over clear
    step(1, 8'h41, 0, 4'b0010);
    chk("R5 set wins", rdata, 1);
    // R6 set/clear ports, R7 whole mask
    step(1, 8'h84, 32'h5, 0);
    step(1, 8'h85, 32'h2, 0);
    chk("R6 set", rdata, 32'h7);
    step(1, 8'h86, 32'h4, 0);
    chk("R6 clear", rdata, 32'h3);
    // R9 shortcut on bit 2, then disabled
    step(1, 8'h80, 32'h4, 0);
    step(0, 8'h00, 0, 4'b0100);
    step(0, 8'h00, 0, 0);
    chk("R9 shortcut pulse", 32'(task_o), 32'h4);
    step(1, 8'h80, 32'h0, 4'b0100);
    step(0, 8'h00, 0, 0);
    chk("R9 pulse uses old shortcut", 32'(task_o), 32'h4);
    // R11 unmapped write does nothing
    step(1, 8'h90, 32'hFFFF_FFFF, 0);
    step(0, 8'h84, 0, 0);
    chk("R11 mask untouched", rdata, 32'h3);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 5);
      case (sel)
        0: a = 8'($urandom_range(0, NT));
        1: a = 8'h40 + 8'($urandom_range(0, NE));
        2: a = 8'h80;
        3: a = 8'h84 + 8'($urandom_range(0, 2));
        4: a = 8'($urandom_range(0, 255));
        default: a = 8'h40 + 8'($urandom_range(0, NE - 1));
      endcase
      step($urandom_range(0, 2) != 0, a, $urandom,
           ($urandom_range(0, 3) == 0) ? NE'($urandom) : '0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule